// File: doc/BRIEF.md
# Nonvolatile Word Program Sequencer

This block controls the timed reprogramming of one word in a 128-word by 8-bit nonvolatile array. It also controls a wipe of the whole array. A request is a single-cycle start pulse that carries a word address, a data byte and a qualifier that selects a full wipe. The sequencer then runs an erase phase, a write phase or both. Each phase lasts a parameterised number of clock cycles, which stands in for a delay in the millisecond range. While a cycle runs, the busy flag stays high. An abort pulse stops the cycle at once.

Each phase is skipped when it would change nothing. The erase phase is skipped when the target word already holds all ones. The write phase is skipped when the data byte has no zero bits. For a period after reset is released, start requests are refused. The array model inside the block is synchronous and powers up erased. It can be inspected through a registered read port.

Top module: `nvm_prog_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, busy is 0. Every word, read through the read port, returns 8'hFF.
- R2: A start sampled in the first INHIBIT_CYC cycles after reset release is ignored: busy stays 0 and no word changes.
- R3: An accepted start raises busy on the next cycle. A word whose content is not 8'hFF, programmed with data that has at least one 0 bit, keeps busy high for ERASE_CYC+WRITE_CYC cycles and afterwards reads back the data byte.
- R4: When the addressed word already reads 8'hFF, the erase phase is skipped: busy lasts WRITE_CYC cycles and the word reads back the data byte.
- R5: When the data byte is 8'hFF and the word is not, only the erase phase runs: busy lasts ERASE_CYC cycles and the word reads 8'hFF.
- R6: When both the word and the data byte are 8'hFF, busy lasts exactly one cycle and the word is unchanged.
- R7: A start with address 0, data 8'hFF and the wipe qualifier at 1 keeps busy high for TOTAL_CYC cycles. Afterwards every word reads 8'hFF.
- R8: The wipe qualifier with any other address or data leaves a normal single-word cycle, which obeys R3 to R6.
- R9: An abort sampled while busy drops busy on the next cycle. Every other word is unchanged, and the target word holds either its old value or 8'hFF.
- R10: A start sampled while busy is ignored. The running cycle keeps its duration and its target.
- R11: rd_data returns the word that was at rd_addr at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle program request |
| req_addr | input | 7 | Target word address |
| req_data | input | 8 | Data byte to program |
| wipe_qual | input | 1 | Qualifier that turns addr 0 / data FF into a whole-array wipe |
| abort | input | 1 | Ends a running cycle immediately |
| busy | output | 1 | High while a cycle runs |
| rd_addr | input | 7 | Inspection read address |
| rd_data | output | 8 | Registered read data |

## Verification
Several properties are checked by assertions on every cycle. Busy stays low for the whole inhibit window. Busy can only rise right after a start pulse. An abort drops busy on the next cycle. No busy stretch runs longer than the longest legal cycle. The bench scenarios cover what depends on data. They show the exact length of each phase combination, and the chosen combination depends on the stored word and the data byte. They also show the contents after a wipe, the limits on damage from an abort, and that a start issued while busy is ignored.

// File: rtl/nvm_prog_pkg.sv
// Shared types for the word program sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package nvm_prog_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ERASE = 3'd1,
        PH_WRITE = 3'd2,
        PH_WIPE  = 3'd3,
        PH_NOOP  = 3'd4
    } phase_t;

    // Larger of two integers, used to size counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_inhibit.sv
// Power-on inhibit window.
// What it does: after reset is released, counts INHIBIT_CYC cycles and then
// raises ready, which stays high until the next reset.
// Assumes: INHIBIT_CYC >= 1.
module nvm_inhibit #(
    parameter int INHIBIT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int IW = $clog2(INHIBIT_CYC + 1);
    localparam logic [IW-1:0] INH_END = IW'(INHIBIT_CYC);

    logic [IW-1:0] win_cnt;

    // Saturating count of the cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (win_cnt != INH_END)
            win_cnt <= win_cnt + 1'b1;
    end

    assign ready = (win_cnt == INH_END);
endmodule

// File: rtl/nvm_cell_array.sv
// Synchronous model of the nonvolatile array.
// What it does: holds DEPTH words. A word erase sets one word to all ones.
// A program clears the bits of one word where the data mask is 0. A wipe sets
// every word to all ones. Provides a combinational peek port for the sequencer
// and a registered inspection read port.
// Assumes: at most one of wipe/erase/program matters per cycle, in that priority.
module nvm_cell_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              erase_we,
    input  logic              prog_we,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              wipe_we,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  row_hit;

    // Row decode, one comparator per word.
    for (genvar w = 0; w < DEPTH; w++) begin : g_row
        assign row_hit[w] = (wr_addr == ADDR_W'(w));
    end

    // Cell update: reset and wipe leave the array erased.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n || wipe_we)
                cells[i] <= '1;
            else if (erase_we && row_hit[i])
                cells[i] <= '1;
            else if (prog_we && row_hit[i])
                cells[i] <= cells[i] & prog_data;
        end
    end

    // Registered inspection read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '1;
        else
            rd_data <= cells[rd_addr];
    end

    assign peek_data = cells[peek_addr];
endmodule

// File: rtl/nvm_phase_ctl.sv
// Phase sequencer for erase, write and wipe.
// What it does: accepts a start when idle and ready. It chooses the phases
// from the stored word and the data byte, times each phase with one counter,
// and pulses the array write enable at the end of each phase. An abort
// returns it to idle and suppresses any pending write.
// Assumes: every phase length >= 1; start ignored unless idle.
module nvm_phase_ctl
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 20,
    parameter int WRITE_CYC = 16,
    parameter int TOTAL_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              wipe_qual,
    input  logic              abort,
    input  logic [DATA_W-1:0] cur_word,
    output logic              busy,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              erase_we,
    output logic              prog_we,
    output logic              wipe_we
);
    localparam int MAXLEN = imax(imax(ERASE_CYC, WRITE_CYC), TOTAL_CYC);
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] ERASE_END = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] WRITE_END = CW'(WRITE_CYC - 1);
    localparam logic [CW-1:0] WIPE_END  = CW'(TOTAL_CYC - 1);

    phase_t        phase, phase_nx;
    logic [CW-1:0] cnt;
    logic          write_pend;
    logic          accept, is_wipe, need_erase, need_write, last;

    // Request decode at the acceptance edge.
    always_comb begin
        accept     = start && ready && (phase == PH_IDLE);
        is_wipe    = wipe_qual && (req_addr == '0) && (&req_data);
        need_erase = ~&cur_word;
        need_write = ~&req_data;
    end

    // End-of-phase detect for the current phase.
    always_comb begin
        unique case (phase)
            PH_ERASE: last = (cnt == ERASE_END);
            PH_WRITE: last = (cnt == WRITE_END);
            PH_WIPE:  last = (cnt == WIPE_END);
            PH_NOOP:  last = 1'b1;
            default:  last = 1'b0;
        endcase
    end

    // Next phase selection, with abort taking priority.
    always_comb begin
        phase_nx = phase;
        if (phase == PH_IDLE) begin
            if (accept) begin
                if (is_wipe)         phase_nx = PH_WIPE;
                else if (need_erase) phase_nx = PH_ERASE;
                else if (need_write) phase_nx = PH_WRITE;
                else                 phase_nx = PH_NOOP;
            end
        end else if (abort) begin
            phase_nx = PH_IDLE;
        end else if (last) begin
            phase_nx = (phase == PH_ERASE && write_pend) ? PH_WRITE : PH_IDLE;
        end
    end

    // Array strobes at the end of a phase that was not aborted.
    always_comb begin
        erase_we = (phase == PH_ERASE) && last && !abort;
        prog_we  = (phase == PH_WRITE) && last && !abort;
        wipe_we  = (phase == PH_WIPE)  && last && !abort;
    end

    // Phase register and phase-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= (phase_nx != phase) ? '0 : cnt + 1'b1;
        end
    end

    // Latch the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr   <= '0;
            tgt_data   <= '1;
            write_pend <= 1'b0;
        end else if (accept) begin
            tgt_addr   <= req_addr;
            tgt_data   <= req_data;
            write_pend <= need_write;
        end
    end

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/nvm_prog_seq.sv
// Top of the word program sequencer.
// What it does: connects the power-on inhibit, the phase sequencer and the
// array model. The peek address follows the request while idle and the
// latched target while busy.
// Assumes: synchronous active-low reset; a single clock domain.
module nvm_prog_seq #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int ERASE_CYC   = 20,
    parameter int WRITE_CYC   = 16,
    parameter int TOTAL_CYC   = 40,
    parameter int INHIBIT_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              wipe_qual,
    input  logic              abort,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              ready;
    logic [ADDR_W-1:0] tgt_addr, peek_addr;
    logic [DATA_W-1:0] tgt_data, cur_word;
    logic              erase_we, prog_we, wipe_we;

    nvm_inhibit #(.INHIBIT_CYC(INHIBIT_CYC)) u_inh (
        .clk(clk), .rst_n(rst_n), .ready(ready)
    );

    // Peek address selection for the erase-skip decision.
    always_comb peek_addr = busy ? tgt_addr : req_addr;

    nvm_phase_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC),
        .WRITE_CYC(WRITE_CYC), .TOTAL_CYC(TOTAL_CYC)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .ready(ready), .start(start),
        .req_addr(req_addr), .req_data(req_data), .wipe_qual(wipe_qual),
        .abort(abort), .cur_word(cur_word), .busy(busy),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .erase_we(erase_we),
        .prog_we(prog_we), .wipe_we(wipe_we)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_addr(tgt_addr), .erase_we(erase_we),
        .prog_we(prog_we), .prog_data(tgt_data), .wipe_we(wipe_we),
        .peek_addr(peek_addr), .peek_data(cur_word),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/nvm_prog_seq_chk.sv
// Assertion checker for the word program sequencer, bound to the top.
// What it does: checks the inhibit window, the busy origin, the abort response
// and the longest busy stretch, using counters of its own.
module nvm_prog_seq_chk #(
    parameter int ERASE_CYC   = 20,
    parameter int WRITE_CYC   = 16,
    parameter int TOTAL_CYC   = 40,
    parameter int INHIBIT_CYC = 32
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic abort,
    input logic busy
);
    localparam int MAXB = (ERASE_CYC + WRITE_CYC > TOTAL_CYC) ?
                          ERASE_CYC + WRITE_CYC : TOTAL_CYC;

    int unsigned since_rst;
    int unsigned busy_run;

    // Cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_rst <= 0;
        else if (since_rst < INHIBIT_CYC) since_rst <= since_rst + 1;
    end

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_inhibit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < INHIBIT_CYC) |-> !busy);

    assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_abort_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> !busy);

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < MAXB));
endmodule

bind nvm_prog_seq nvm_prog_seq_chk #(
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC),
    .TOTAL_CYC(TOTAL_CYC), .INHIBIT_CYC(INHIBIT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy)
);

// File: tb/nvm_prog_seq_test.sv
module nvm_prog_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int EC = 20, WC = 16, TC = 40, IC = 32;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, wipe_qual = 1'b0, abort = 1'b0;
    logic [6:0] req_addr = '0, rd_addr = '0;
    logic [7:0] req_data = '0;
    logic       busy;
    logic [7:0] rd_data;

    int total = 0, bad = 0;
    int cyc = 0;
    logic [7:0] model [DEPTH];

    nvm_prog_seq #(.ERASE_CYC(EC), .WRITE_CYC(WC), .TOTAL_CYC(TC),
                   .INHIBIT_CYC(IC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .req_data(req_data), .wipe_qual(wipe_qual), .abort(abort),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog (all reqs) actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected busy length, computed from the requirements.
    function automatic int exp_len(input logic [6:0] a, input logic [7:0] d,
                                   input logic q);
        if (q && a == 0 && d == 8'hFF) return TC;
        if (model[a] != 8'hFF && d != 8'hFF) return EC + WC;
        if (model[a] != 8'hFF) return EC;
        if (d != 8'hFF) return WC;
        return 1;
    endfunction

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic scan(input string req, input int skip);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            if (i != skip) begin
                rd(7'(i), v);
                chk(req, v, model[i]);
            end
        end
    endtask

    // Issue one request. ab_at>0 aborts at that busy cycle; dbl injects a
    // second start while busy.
    task automatic req(input string tag, input logic [6:0] a, input logic [7:0] d,
                       input logic q, input int ab_at, input bit dbl);
        int n, el;
        logic [7:0] v, old;
        el  = exp_len(a, d, q);
        old = model[a];
        req_addr = a; req_data = d; wipe_qual = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " busy rise R3"}, busy, 1);
        n = 1;
        while (1) begin
            if (ab_at > 0 && n == ab_at) begin
                abort = 1'b1;
                @(negedge clk);
                abort = 1'b0;
                chk("abort drops busy R9", busy, 0);
                break;
            end
            if (dbl && n == 2) begin
                req_addr = a ^ 7'h01; req_data = 8'h00; wipe_qual = 1'b0; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (!busy) break;
            n++;
        end
        if (ab_at > 0) begin
            rd(a, v);
            total++;
            if (v != old && v != 8'hFF) begin
                bad++;
                $display("FAIL R9 target actual=%0h expected=%0h or ff", v, old);
            end
            model[a] = v;
            scan("abort others R9", a);
        end else begin
            chk({tag, " busy length"}, n, el);
            if (q && a == 0 && d == 8'hFF) begin
                for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
                scan("wipe contents R7", -1);
            end else begin
                model[a] = d;
                rd(a, v);
                chk({tag, " word value R11"}, v, d);
                if (dbl) begin
                    rd(a ^ 7'h01, v);
                    chk("start while busy R10", v, model[a ^ 7'h01]);
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int seed;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("reset busy R1", busy, 0);
        rst_n = 1'b1;
        chk("reset busy R1", busy, 0);
        // R2: request inside the inhibit window
        @(negedge clk);
        req_addr = 7'd5; req_data = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("inhibit no busy R2", busy, 0);
        rd(7'd5, v);
        chk("inhibit word R2", v, 8'hFF);
        repeat (IC + 4) @(negedge clk);
        chk("inhibit still idle R2", busy, 0);
        scan("reset contents R1", -1);

        req("R4", 7'd10, 8'h5A, 1'b0, 0, 1'b0);
        req("R3", 7'd10, 8'h3C, 1'b0, 0, 1'b0);
        req("R5", 7'd10, 8'hFF, 1'b0, 0, 1'b0);
        req("R6", 7'd10, 8'hFF, 1'b0, 0, 1'b0);
        req("R10", 7'd40, 8'h81, 1'b0, 0, 1'b1);
        req("R4", 7'd3, 8'h0F, 1'b0, 0, 1'b0);
        req("R8", 7'd3, 8'hFF, 1'b1, 0, 1'b0);
        req("R8", 7'd0, 8'h00, 1'b1, 0, 1'b0);
        req("R4", 7'd127, 8'h77, 1'b0, 0, 1'b0);
        req("R7", 7'd0, 8'hFF, 1'b1, 0, 1'b0);
        req("R4", 7'd20, 8'h11, 1'b0, 0, 1'b0);
        req("R9", 7'd20, 8'h22, 1'b0, 5, 1'b0);
        req("R9", 7'd20, 8'h44, 1'b0, EC + 3, 1'b0);

        // Constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic [6:0] a;
            logic [7:0] d;
            logic q;
            int ab;
            a  = ($urandom % 4 == 0) ? 7'd0 : 7'($urandom % 16);
            d  = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            q  = ($urandom % 5 == 0);
            ab = (!(q && a == 0 && d == 8'hFF) && $urandom % 6 == 0) ?
                 int'($urandom % 8) + 1 : 0;
            if (ab > exp_len(a, d, q)) ab = 0;
            req("R3 rnd", a, d, q, ab, 1'b0);
        end
        scan("final contents R3", -1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule